// File: doc/BRIEF.md
# Text-Command Register Write Bridge

This block sits behind a host serial receiver and turns short ASCII command lines into single register writes on a parallel bus. Such a bus is typical of frequency-synthesizer chips. A line holds the letter `B` (or `b`), then a register address of two hex digits, an optional single space, a data byte of two hex digits, and a carriage return. When a well-formed line ends, the block drives the address and data buses. It then pulses an active-low write strobe. After a short gap it pulses an update strobe, which makes the newly written register take effect in the target.

Each command gets a one-byte answer for the host transmitter. A completed write answers `*`. A malformed line is dropped and answers `?`. A busy flag is high while the bus sequence runs, and received characters are ignored during that time. All bus timings are parameters. The defaults give one cycle of setup, a two-cycle write strobe, a two-cycle gap and a two-cycle update pulse.

Top module: `cmd_poke_bridge`

## Requirements
- R1: A line of `B`/`b`, two address hex digits, an optional single space (0x20), two data hex digits and CR (0x0D) causes exactly one write pulse. During that pulse `reg_addr` carries the address and `reg_data` carries the data; the first digit of each field is the high nibble.
- R2: Hex digits are accepted as 0-9, A-F and a-f. A digit in upper case and the same digit in lower case give the same value.
- R3: `reg_addr` and `reg_data` hold their new value for at least one cycle before `wr_n` falls. They stay unchanged while `wr_n` is low, for one cycle after it rises, and until the next valid command.
- R4: `wr_n` is high at idle and goes low for exactly 2 consecutive cycles per write, starting 1 cycle after the bus is loaded.
- R5: `io_upd` is a 2-cycle active-high pulse. It rises 2 cycles after `wr_n` rises and never overlaps the write strobe.
- R6: A completed write gives a one-cycle `ack_valid` with `ack_data` = 0x2A (`*`). This happens in the cycle after the last update cycle, which is the same cycle that `busy` falls.
- R7: Inside a command, a non-hex character where a digit is expected, a CR before the data field is complete, or any other character where CR is expected ends the command. This includes a space directly after `B` and a third data digit. The block then gives `ack_valid` with `ack_data` = 0x3F (`?`) in the cycle after that character, and no write occurs.
- R8: `busy` is high from the cycle after the accepted CR until the update pulse ends. Characters received while `busy` is high are ignored.
- R9: Outside a command, characters other than `B`/`b` are ignored and produce neither an acknowledge nor a write.
- R10: After reset, `wr_n`=1, `io_upd`=0, `busy`=0, `ack_valid`=0, and `reg_addr` and `reg_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Single-cycle qualifier for `rx_data` |
| reg_addr | output | 8 | Register address bus |
| reg_data | output | 8 | Register data bus |
| wr_n | output | 1 | Active-low write strobe |
| io_upd | output | 1 | Active-high update strobe |
| busy | output | 1 | Bus sequence in progress |
| ack_data | output | 8 | Acknowledge code (`*` or `?`) |
| ack_valid | output | 1 | Single-cycle qualifier for `ack_data` |

## Verification
The assertions watch the bus timing on every cycle. They check bus stability around the write strobe, the exact strobe widths, the gap before the update pulse, and that strobes only occur while busy. They also check that the `*` code coincides with busy falling and that only the two legal codes appear. Only the bench scenarios can show the parsing behaviour. These are the address and data values that reach the bus for every address, the case and separator variants, the rejection of malformed lines with no write, and the silent discarding of characters during a busy sequence or outside a command.

// File: rtl/poke_pkg.sv
package poke_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_SP   = 8'h20;
  localparam logic [7:0] CH_UB   = 8'h42;
  localparam logic [7:0] CH_LB   = 8'h62;
  localparam logic [7:0] CODE_OK = 8'h2A;
  localparam logic [7:0] CODE_BAD = 8'h3F;

  typedef enum logic [2:0] {
    P_IDLE, P_AH, P_AL, P_SEP, P_DH, P_DL, P_END
  } pstate_t;

  // returns {is_hex, nibble}
  function automatic logic [4:0] hex_val(input logic [7:0] c);
    logic [4:0] r;
    r = 5'd0;
    if (c >= 8'h30 && c <= 8'h39)      r = {1'b1, 4'(c - 8'h30)};
    else if (c >= 8'h41 && c <= 8'h46) r = {1'b1, 4'(c - 8'h37)};
    else if (c >= 8'h61 && c <= 8'h66) r = {1'b1, 4'(c - 8'h57)};
    return r;
  endfunction
endpackage

// File: rtl/poke_parser.sv
module poke_parser
  import poke_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        ch,
  input  logic              ch_en,
  output logic              fire,
  output logic              bad,
  output logic [BYTE_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_data
);
  pstate_t     st, st_n;
  logic [4:0]  hv;
  logic        is_hex;
  logic [3:0]  nib;
  logic [7:0]  a_r, d_r;

  assign hv     = hex_val(ch);
  assign is_hex = hv[4];
  assign nib    = hv[3:0];

  always_comb begin
    st_n = st;
    fire = 1'b0;
    bad  = 1'b0;
    if (ch_en) begin
      case (st)
        P_IDLE: if (ch == CH_UB || ch == CH_LB) st_n = P_AH;
        P_AH:   if (is_hex) st_n = P_AL; else bad = 1'b1;
        P_AL:   if (is_hex) st_n = P_SEP; else bad = 1'b1;
        P_SEP:  if (ch == CH_SP) st_n = P_DH;
                else if (is_hex) st_n = P_DL;
                else bad = 1'b1;
        P_DH:   if (is_hex) st_n = P_DL; else bad = 1'b1;
        P_DL:   if (is_hex) st_n = P_END; else bad = 1'b1;
        P_END:  if (ch == CH_CR) begin fire = 1'b1; st_n = P_IDLE; end
                else bad = 1'b1;
        default: st_n = P_IDLE;
      endcase
      if (bad) st_n = P_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= P_IDLE;
      a_r <= '0;
      d_r <= '0;
    end else begin
      st <= st_n;
      if (ch_en && is_hex) begin
        case (st)
          P_AH:         a_r[7:4] <= nib;
          P_AL:         a_r[3:0] <= nib;
          P_SEP, P_DH:  d_r[7:4] <= nib;
          P_DL:         d_r[3:0] <= nib;
          default: ;
        endcase
      end
    end
  end

  assign cmd_addr = a_r;
  assign cmd_data = d_r;
endmodule

// File: rtl/poke_seq.sv
module poke_seq
  import poke_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WR_LOW    = 2,
  parameter int UPD_GAP   = 2,
  parameter int UPD_LEN   = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] in_addr,
  input  logic [BYTE_W-1:0] in_data,
  output logic [BYTE_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_data,
  output logic              wr_n,
  output logic              upd,
  output logic              busy,
  output logic              last
);
  localparam int WR_BEG = SETUP_CYC;
  localparam int WR_END = SETUP_CYC + WR_LOW;
  localparam int UP_BEG = WR_END + UPD_GAP;
  localparam int UP_END = UP_BEG + UPD_LEN;
  localparam int CW     = $clog2(UP_END + 1);

  logic [CW-1:0] cnt, cnt_n;

  assign cnt_n = cnt + 1'b1;
  assign last  = busy && (cnt_n == CW'(UP_END));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_data <= '0;
      wr_n     <= 1'b1;
      upd      <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else if (!busy) begin
      if (start) begin
        bus_addr <= in_addr;
        bus_data <= in_data;
        busy     <= 1'b1;
        cnt      <= '0;
      end
    end else begin
      cnt  <= cnt_n;
      wr_n <= !(cnt_n >= CW'(WR_BEG) && cnt_n < CW'(WR_END));
      upd  <= (cnt_n >= CW'(UP_BEG) && cnt_n < CW'(UP_END));
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_poke_bridge.sv
module cmd_poke_bridge
  import poke_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WR_LOW    = 2,
  parameter int UPD_GAP   = 2,
  parameter int UPD_LEN   = 2
)(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_data,
  output logic       wr_n,
  output logic       io_upd,
  output logic       busy,
  output logic [7:0] ack_data,
  output logic       ack_valid
);
  logic              fire, bad, last;
  logic [BYTE_W-1:0] p_addr, p_data;

  poke_parser u_parse (
    .clk      (clk),
    .rst      (rst),
    .ch       (rx_data),
    .ch_en    (rx_valid && !busy),
    .fire     (fire),
    .bad      (bad),
    .cmd_addr (p_addr),
    .cmd_data (p_data)
  );

  poke_seq #(
    .SETUP_CYC (SETUP_CYC),
    .WR_LOW    (WR_LOW),
    .UPD_GAP   (UPD_GAP),
    .UPD_LEN   (UPD_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (fire),
    .in_addr  (p_addr),
    .in_data  (p_data),
    .bus_addr (reg_addr),
    .bus_data (reg_data),
    .wr_n     (wr_n),
    .upd      (io_upd),
    .busy     (busy),
    .last     (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      ack_data  <= '0;
    end else begin
      ack_valid <= bad || last;
      if (bad || last) ack_data <= last ? CODE_OK : CODE_BAD;
    end
  end
endmodule

// File: rtl/poke_bridge_chk.sv
module poke_bridge_chk #(
  parameter int WR_LOW  = 2,
  parameter int UPD_GAP = 2,
  parameter int UPD_LEN = 2
)(
  input logic       clk,
  input logic       rst,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_data,
  input logic       wr_n,
  input logic       io_upd,
  input logic       busy,
  input logic [7:0] ack_data,
  input logic       ack_valid
);
  logic [7:0] low_c, high_c, upd_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_c <= '0; high_c <= '0; upd_c <= '0;
    end else begin
      low_c  <= !wr_n ? low_c + 8'd1 : 8'd0;
      high_c <= !wr_n ? 8'd0 : (high_c == 8'hFF ? high_c : high_c + 8'd1);
      upd_c  <= io_upd ? upd_c + 8'd1 : 8'd0;
    end
  end

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $stable(reg_addr) && $stable(reg_data)); // R3
  AST_ADDR_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> $stable(reg_addr) && $stable(reg_data)); // R3
  AST_ADDR_HOLD_AFTER: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |=> $stable(reg_addr) && $stable(reg_data)); // R3
  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> low_c == 8'(WR_LOW)); // R4
  AST_UPD_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(io_upd) |-> high_c == 8'(UPD_GAP)); // R5
  AST_UPD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(io_upd) |-> upd_c == 8'(UPD_LEN)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!wr_n && io_upd)); // R5
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!wr_n || io_upd) |-> busy); // R8
  AST_DONE_ACK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ack_valid && ack_data == 8'h2A); // R6
  AST_ACK_CODE: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ack_data == 8'h2A || ack_data == 8'h3F)); // R7
endmodule

bind cmd_poke_bridge poke_bridge_chk #(
  .WR_LOW (WR_LOW), .UPD_GAP (UPD_GAP), .UPD_LEN (UPD_LEN)
) u_chk (
  .clk (clk), .rst (rst), .reg_addr (reg_addr), .reg_data (reg_data),
  .wr_n (wr_n), .io_upd (io_upd), .busy (busy),
  .ack_data (ack_data), .ack_valid (ack_valid)
);

// File: tb/sim_cmd_poke_bridge.sv
`timescale 1ns/1ps
module sim_cmd_poke_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] reg_addr, reg_data, ack_data;
  logic       wr_n, io_upd, busy, ack_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmd_poke_bridge u0 (
    .clk (clk), .rst (rst), .rx_data (rx_data), .rx_valid (rx_valid),
    .reg_addr (reg_addr), .reg_data (reg_data), .wr_n (wr_n),
    .io_upd (io_upd), .busy (busy), .ack_data (ack_data), .ack_valid (ack_valid)
  );

  // port monitor, sampled at falling edges
  int cyc = 0, nwr = 0, nack = 0;
  int wr_fall = 0, wr_rise = 0, up_rise = 0, up_fall = 0, ack_cyc = 0;
  logic [7:0] cap_addr = 0, cap_data = 0, ack_code = 0;
  logic prev_wr = 1'b1, prev_up = 1'b0, setup_ok = 1'b0;
  logic [7:0] prev_addr = 0, prev_data = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (prev_wr && !wr_n) begin
        wr_fall <= cyc; nwr <= nwr + 1;
        cap_addr <= reg_addr; cap_data <= reg_data;
        setup_ok <= (prev_addr == reg_addr) && (prev_data == reg_data);
      end
      if (!prev_wr && wr_n) wr_rise <= cyc;
      if (!prev_up && io_upd) up_rise <= cyc;
      if (prev_up && !io_upd) up_fall <= cyc;
      if (ack_valid) begin ack_cyc <= cyc; ack_code <= ack_data; nack <= nack + 1; end
    end
    prev_wr <= wr_n; prev_up <= io_upd;
    prev_addr <= reg_addr; prev_data <= reg_data;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_ch(input logic [7:0] c);
    @(negedge clk);
    rx_data = c; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_ch(s[i]);
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit up);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return (up ? 8'h41 : 8'h61) + 8'(n) - 8'd10;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic good_cmd(input logic [7:0] a, input logic [7:0] d,
                          input bit up, input bit sp, input bit lb);
    int w0, k0;
    w0 = nwr; k0 = nack;
    send_ch(lb ? 8'h62 : 8'h42);
    send_ch(hexc(a[7:4], up)); send_ch(hexc(a[3:0], !up));
    if (sp) send_ch(8'h20);
    send_ch(hexc(d[7:4], !up)); send_ch(hexc(d[3:0], up));
    send_ch(8'h0D);
    wait_cyc(12);
    check(nwr == w0 + 1, "R1", "write count", nwr - w0, 1);
    check(cap_addr == a, "R1", "addr", cap_addr, a);
    check(cap_data == d, "R2", "data", cap_data, d);
    check(setup_ok, "R3", "setup", setup_ok, 1);
    check(wr_rise - wr_fall == 2, "R4", "wr width", wr_rise - wr_fall, 2);
    check(up_rise - wr_rise == 2, "R5", "upd gap", up_rise - wr_rise, 2);
    check(up_fall - up_rise == 2, "R5", "upd width", up_fall - up_rise, 2);
    check(nack == k0 + 1 && ack_code == 8'h2A, "R6", "ack code", ack_code, 8'h2A);
    check(ack_cyc == up_fall, "R6", "ack cycle", ack_cyc, up_fall);
    check(!busy && reg_addr == a && reg_data == d, "R3", "bus held", reg_addr, a);
  endtask

  task automatic bad_cmd(input string s, input string req);
    int w0, k0;
    logic [7:0] a0, d0;
    w0 = nwr; k0 = nack; a0 = reg_addr; d0 = reg_data;
    send_str(s);
    wait_cyc(6);
    check(nwr == w0, req, "no write", nwr - w0, 0);
    check(nack == k0 + 1 && ack_code == 8'h3F, req, "error ack", ack_code, 8'h3F);
    check(reg_addr == a0 && reg_data == d0, req, "bus unchanged", reg_addr, a0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0, k0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    // R10 reset state
    check(wr_n === 1'b1 && io_upd === 1'b0, "R10", "strobes", {wr_n, io_upd}, 2);
    check(busy === 1'b0 && ack_valid === 1'b0, "R10", "busy/ack", {busy, ack_valid}, 0);
    check(reg_addr === 8'h00 && reg_data === 8'h00, "R10", "buses", reg_addr, 0);

    // R1 R2 sweep over every address, alternating case, separator and letter
    for (int a = 0; a < 256; a++)
      good_cmd(8'(a), 8'((a * 37 + 11) & 255), a[0], a[1], a[2]);

    // R7 malformed lines
    good_cmd(8'h5A, 8'hC3, 1'b1, 1'b0, 1'b0);
    bad_cmd("B1G", "R7");
    bad_cmd("B12 3\r", "R7");
    bad_cmd("B12Z", "R7");
    bad_cmd("B 1", "R7");
    bad_cmd("B1\r", "R7");
    bad_cmd("B12345", "R7");
    wait_cyc(4);
    send_str("6\r");
    wait_cyc(4);

    // R9 idle garbage
    w0 = nwr; k0 = nack;
    send_str("x1234\r zq\r");
    wait_cyc(6);
    check(nwr == w0 && nack == k0, "R9", "idle ignored", nack - k0, 0);

    // R8 characters during busy
    w0 = nwr; k0 = nack;
    send_str("b7e 81\r");
    check(busy === 1'b1, "R8", "busy after CR", busy, 1);
    send_str("B12");
    wait_cyc(8);
    send_str("34\r");
    wait_cyc(8);
    check(nwr == w0 + 1, "R8", "one write only", nwr - w0, 1);
    check(nack == k0 + 1, "R8", "one ack only", nack - k0, 1);
    check(reg_addr == 8'h7E && reg_data == 8'h81, "R8", "bus kept", reg_addr, 8'h7E);
    check(!busy, "R8", "busy cleared", busy, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule